// File: doc/BRIEF.md
# Chip-Select Serial Readout Emulator for an 18-bit SAR Converter

This block reproduces the digital behaviour of an 18-bit successive-approximation converter whose results are read over a 4-wire, chip-select style serial link with no busy indicator. A host drives the convert strobe, the per-device select line and the serial clock. The block is clocked by a fast system clock and samples these three lines. It times the conversion and captures a parallel sample word when the conversion ends. It then shifts that word out MSB first whenever the select line is pulled low. The serial output is modelled as a data bit plus an output enable, so several instances can share one wire on a bench or in an emulation fabric.

The convert line rising while select is high starts a conversion and releases the output. The convert line must then stay high through the conversion and the readback that follows. A select line that drops during the conversion returns the earlier result and raises a flag. A select line still low when the conversion ends is a protocol error, and no busy pulse is emitted.

Top module: `adc_csmode_emu`

## Requirements
- R1: A rising edge on `cnvIn` while `sdiIn` is high starts a conversion. `convBusy` goes high, `sdoOe` is 0, and `protoErr` and `staleRead` are cleared.
- R2: With no conversion mode active, `sdoOe` is 1 and `sdoData` is 0 while `cnvIn` and `sdiIn` are both low. Otherwise `sdoOe` is 0.
- R3: A conversion lasts `convCycles` system clocks, with a value of 0 treated as 1. Then `convBusy` drops, `acqIdle` rises, and the value on `sampleWord` in that last cycle becomes the new result.
- R4: A falling edge on `cnvIn` during conversion or acquisition returns the block to idle. `convBusy` and `acqIdle` go low and any readback in progress ends.
- R5: A falling edge on `sdiIn` during acquisition sets `sdoOe` to 1 and puts result bit 17 (the MSB) on `sdoData`.
- R6: While reading, each falling edge of `sckIn` presents the next lower result bit. The 18th falling edge sets `sdoOe` back to 0.
- R7: If `sdiIn` is low when a conversion ends, `protoErr` is set until the next conversion starts. The output is not driven as a busy indicator.
- R8: A falling edge on `sdiIn` during a conversion starts a readback of the previous result and sets `staleRead`.
- R9: A rising edge on `sdiIn` during a readback ends it at once, and `sdoOe` goes to 0.
- R10: Falling edges of `sckIn` while no readback is active have no effect. A later readback still begins with the MSB.
- R11: A rising edge on `cnvIn` while `sdiIn` is low starts no conversion, and `convBusy` stays 0.
- R12: Each of `cnvIn`, `sdiIn` and `sckIn` passes through a two-flop synchronizer and an edge detector. An input change therefore takes effect on the third system clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| cnvIn | input | 1 | Convert strobe from the host |
| sdiIn | input | 1 | Mode select / read select from the host |
| sckIn | input | 1 | Serial clock from the host |
| sampleWord | input | 18 | Parallel value captured at the end of a conversion |
| convCycles | input | 16 | Conversion time in system clocks |
| sdoData | output | 1 | Serial data bit |
| sdoOe | output | 1 | Serial output enable (0 means high impedance) |
| convBusy | output | 1 | Conversion in progress |
| acqIdle | output | 1 | Acquisition phase, converter powered down |
| protoErr | output | 1 | Select was low when the conversion ended |
| staleRead | output | 1 | A readback began before the conversion finished |

## Verification
The hardest case to reach is the overlap of a readback with a running conversion. It needs a long `convCycles` setting. The select line has to drop inside that window, and all 18 serial clocks have to finish before the counter expires. The stimulus covers two endings of that overlap. In one, select goes back high in time and the old result comes out. In the other, select is held low across the end of the conversion, which must raise `protoErr` and leave the output released.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_ACQ  = 2'd2
  } phase_t;

  typedef struct packed {
    logic latchResult;
    logic loadShift;
    logic shiftOut;
  } dp_strobe_t;

endpackage

// File: rtl/adc_emu_sync_edge.sv
module adc_emu_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic levelOut,
  output logic riseOut,
  output logic fallOut
);

  logic [STAGES-1:0] chain;
  logic              prevLevel;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= 1'b0;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= chain[STAGES-1];
  end

  assign levelOut = chain[STAGES-1];
  assign riseOut  = chain[STAGES-1] & ~prevLevel;
  assign fallOut  = ~chain[STAGES-1] & prevLevel;

endmodule

// File: rtl/adc_emu_ctrl.sv
module adc_emu_ctrl
  import adc_emu_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cnvLvl,
  input  logic             cnvRise,
  input  logic             cnvFall,
  input  logic             sdiLvl,
  input  logic             sdiRise,
  input  logic             sdiFall,
  input  logic             sckFall,
  input  logic [CNT_W-1:0] convCycles,
  output dp_strobe_t       dpCtl,
  output phase_t           phase,
  output logic             reading,
  output logic             driveLow,
  output logic             protoErr,
  output logic             staleRead
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitCnt;
  logic             active;
  logic             convDone;

  assign active   = (phase != PH_IDLE) && !cnvFall;
  assign convDone = (phase == PH_CONV) && !cnvFall && (cnt <= CNT_W'(1));
  assign driveLow = (phase == PH_IDLE) && !sdiLvl && !cnvLvl;

  always_comb begin
    dpCtl             = '0;
    dpCtl.latchResult = convDone;
    dpCtl.loadShift   = active && !reading && sdiFall;
    dpCtl.shiftOut    = active && reading && !sdiRise && sckFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      reading   <= 1'b0;
      bitCnt    <= '0;
      protoErr  <= 1'b0;
      staleRead <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          reading <= 1'b0;
          if (cnvRise && sdiLvl) begin
            phase     <= PH_CONV;
            cnt       <= (convCycles == '0) ? CNT_W'(1) : convCycles;
            protoErr  <= 1'b0;
            staleRead <= 1'b0;
          end
        end
        default: begin
          if (cnvFall) begin
            phase   <= PH_IDLE;
            reading <= 1'b0;
          end else begin
            if (reading) begin
              if (sdiRise) begin
                reading <= 1'b0;
              end else if (sckFall) begin
                if (bitCnt == LAST_BIT) reading <= 1'b0;
                else                    bitCnt  <= bitCnt + 1'b1;
              end
            end else if (sdiFall) begin
              reading <= 1'b1;
              bitCnt  <= '0;
              if (phase == PH_CONV) staleRead <= 1'b1;
            end
            if (phase == PH_CONV) begin
              if (convDone) begin
                phase <= PH_ACQ;
                if (!sdiLvl) protoErr <= 1'b1;
              end else begin
                cnt <= cnt - 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/adc_emu_datapath.sv
module adc_emu_datapath
  import adc_emu_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        dpCtl,
  input  logic [DATA_W-1:0] sampleWord,
  output logic              msbBit
);

  logic [DATA_W-1:0] resultReg;
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultReg <= '0;
    else if (dpCtl.latchResult) resultReg <= sampleWord;
  end

  generate
    if (DATA_W > 1) begin : g_wide
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                shiftReg <= '0;
        else if (dpCtl.loadShift) shiftReg <= resultReg;
        else if (dpCtl.shiftOut)  shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                shiftReg <= '0;
        else if (dpCtl.loadShift) shiftReg <= resultReg;
      end
    end
  endgenerate

  assign msbBit = shiftReg[DATA_W-1];

endmodule

// File: rtl/adc_csmode_emu.sv
module adc_csmode_emu
  import adc_emu_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cnvIn,
  input  logic              sdiIn,
  input  logic              sckIn,
  input  logic [DATA_W-1:0] sampleWord,
  input  logic [CNT_W-1:0]  convCycles,
  output logic              sdoData,
  output logic              sdoOe,
  output logic              convBusy,
  output logic              acqIdle,
  output logic              protoErr,
  output logic              staleRead
);

  localparam int N_IN = 3;
  localparam int IDX_CNV = 0;
  localparam int IDX_SDI = 1;
  localparam int IDX_SCK = 2;

  logic [N_IN-1:0] rawIn;
  logic [N_IN-1:0] lvl;
  logic [N_IN-1:0] rise;
  logic [N_IN-1:0] fall;

  assign rawIn = {sckIn, sdiIn, cnvIn};

  genvar g;
  generate
    for (g = 0; g < N_IN; g++) begin : g_sync
      adc_emu_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rstN    (rstN),
        .asyncIn (rawIn[g]),
        .levelOut(lvl[g]),
        .riseOut (rise[g]),
        .fallOut (fall[g])
      );
    end
  endgenerate

  dp_strobe_t dpCtl;
  phase_t     phase;
  logic       reading;
  logic       driveLow;
  logic       msbBit;

  adc_emu_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cnvLvl    (lvl[IDX_CNV]),
    .cnvRise   (rise[IDX_CNV]),
    .cnvFall   (fall[IDX_CNV]),
    .sdiLvl    (lvl[IDX_SDI]),
    .sdiRise   (rise[IDX_SDI]),
    .sdiFall   (fall[IDX_SDI]),
    .sckFall   (fall[IDX_SCK]),
    .convCycles(convCycles),
    .dpCtl     (dpCtl),
    .phase     (phase),
    .reading   (reading),
    .driveLow  (driveLow),
    .protoErr  (protoErr),
    .staleRead (staleRead)
  );

  adc_emu_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtl     (dpCtl),
    .sampleWord(sampleWord),
    .msbBit    (msbBit)
  );

  assign sdoOe    = reading | driveLow;
  assign sdoData  = reading & msbBit;
  assign convBusy = (phase == PH_CONV);
  assign acqIdle  = (phase == PH_ACQ);

endmodule

// File: rtl/adc_emu_checker.sv
module adc_emu_checker (
  input logic clk,
  input logic rstN,
  input logic sdoData,
  input logic sdoOe,
  input logic convBusy,
  input logic acqIdle,
  input logic protoErr,
  input logic staleRead
);

  assert_start_clean_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convBusy) |-> (!sdoOe && !protoErr && !staleRead));

  assert_idle_drive_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!convBusy && !acqIdle && sdoOe) |-> !sdoData);

  assert_acq_from_conv_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(acqIdle) |-> $past(convBusy));

  assert_err_at_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protoErr) |-> (acqIdle && $past(convBusy)));

  assert_stale_drives_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(staleRead) |-> (convBusy && sdoOe));

endmodule

bind adc_csmode_emu adc_emu_checker i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sdoData  (sdoData),
  .sdoOe    (sdoOe),
  .convBusy (convBusy),
  .acqIdle  (acqIdle),
  .protoErr (protoErr),
  .staleRead(staleRead)
);

// File: tb/test_adc_csmode_emu.sv
module test_adc_csmode_emu;

  localparam int DW = 18;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cnvIn = 1'b0, sdiIn = 1'b1, sckIn = 1'b0;
  logic [DW-1:0] sampleWord = '0;
  logic [CW-1:0] convCycles = 16'd20;
  logic sdoData, sdoOe, convBusy, acqIdle, protoErr, staleRead;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4ns clk = ~clk;

  adc_csmode_emu i_adc_csmode_emu (
    .clk(clk), .rstN(rstN), .cnvIn(cnvIn), .sdiIn(sdiIn), .sckIn(sckIn),
    .sampleWord(sampleWord), .convCycles(convCycles),
    .sdoData(sdoData), .sdoOe(sdoOe), .convBusy(convBusy), .acqIdle(acqIdle),
    .protoErr(protoErr), .staleRead(staleRead)
  );

  // behavioural reference: 0 idle, 1 converting, 2 acquisition
  int  mState = 0;
  int  mCnt = 0;
  int  mShifted = 0;
  bit  mReading = 0, mErr = 0, mStale = 0;
  logic [DW-1:0] mResult = '0;
  bit  mQ[$];
  bit  s1[3], s2[3], pv[3];

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mReading = 0; mErr = 0; mStale = 0; mResult = '0;
      mQ.delete(); mShifted = 0;
      for (int k = 0; k < 3; k++) begin s1[k] = 0; s2[k] = 0; pv[k] = 0; end
    end else begin
      bit cR, cF, dR, dF, kF;
      cR = s2[0] && !pv[0]; cF = !s2[0] && pv[0];
      dR = s2[1] && !pv[1]; dF = !s2[1] && pv[1];
      kF = !s2[2] && pv[2];
      if (mState == 0) begin
        mReading = 0;
        if (cR && s2[1]) begin
          mState = 1; mCnt = (convCycles == 0) ? 1 : int'(convCycles);
          mErr = 0; mStale = 0;
        end
      end else if (cF) begin
        mState = 0; mReading = 0;
      end else begin
        if (mReading) begin
          if (dR) mReading = 0;
          else if (kF) begin
            void'(mQ.pop_front());
            mShifted++;
            if (mShifted == DW) mReading = 0;
          end
        end else if (dF) begin
          mReading = 1; mShifted = 0; mQ.delete();
          for (int b = DW - 1; b >= 0; b--) mQ.push_back(mResult[b]);
          if (mState == 1) mStale = 1;
        end
        if (mState == 1) begin
          if (mCnt <= 1) begin
            mResult = sampleWord; mState = 2;
            if (!s2[1]) mErr = 1;
          end else mCnt--;
        end
      end
      for (int k = 0; k < 3; k++) begin pv[k] = s2[k]; s2[k] = s1[k]; end
      s1[0] = cnvIn; s1[1] = sdiIn; s1[2] = sckIn;
    end
  end

  function automatic string stateTag();
    if (mState == 0) return "R2";
    if (mReading) return "R6";
    if (mState == 1) return "R3";
    return "R4";
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [5:0] act, exp;
      bit eOe, eData;
      eOe   = mReading ? 1'b1 : (mState == 0 && !s2[1] && !s2[0]);
      eData = mReading ? mQ[0] : 1'b0;
      act = {sdoOe, sdoData, convBusy, acqIdle, protoErr, staleRead};
      exp = {eOe, eData, mState == 1, mState == 2, mErr, mStale};
      chk(act === exp, {"model ", stateTag()}, 32'(act), 32'(exp));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sckPulse();
    sckIn = 1'b1; tick(3);
    sckIn = 1'b0; tick(3);
  endtask

  task automatic readWord(logic [DW-1:0] expWord, string tag);
    sdiIn = 1'b0; tick(4);
    chk(sdoOe === 1'b1, {tag, " oe at start"}, 32'(sdoOe), 1);
    chk(sdoData === expWord[DW-1], {tag, " msb"}, 32'(sdoData), 32'(expWord[DW-1]));
    for (int i = 1; i < DW; i++) begin
      sckPulse();
      chk(sdoData === expWord[DW-1-i], "R6 bit", 32'(sdoData), 32'(expWord[DW-1-i]));
    end
    sckPulse();
    chk(sdoOe === 1'b0, "R6 release after last fall", 32'(sdoOe), 0);
  endtask

  task automatic startConv(logic [CW-1:0] cyc, logic [DW-1:0] word);
    convCycles = cyc; sampleWord = word;
    sdiIn = 1'b1; cnvIn = 1'b1;
  endtask

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk(sdoOe === 1'b1 && sdoData === 1'b0 && convBusy === 1'b0, "R2 reset drive low",
        {sdoOe, sdoData, convBusy}, 3'b100);
    rstN = 1'b1; tick(4);
    chk(sdoOe === 1'b0, "R2 sdi high releases", 32'(sdoOe), 0);
    sdiIn = 1'b0; tick(4);
    chk(sdoOe === 1'b1 && sdoData === 1'b0, "R2 both low drives 0", {sdoOe, sdoData}, 2'b10);

    // R11: convert edge with select low
    cnvIn = 1'b1; tick(6);
    chk(convBusy === 1'b0, "R11 no conversion", 32'(convBusy), 0);
    cnvIn = 1'b0; sdiIn = 1'b1; tick(4);

    // R1/R3/R12: normal conversion, exact latency
    startConv(16'd20, 18'h2A5C3);
    tick(2);
    chk(convBusy === 1'b0, "R12 not yet started", 32'(convBusy), 0);
    tick(1);
    chk(convBusy === 1'b1 && sdoOe === 1'b0, "R1 started", {convBusy, sdoOe}, 2'b10);
    tick(19);
    chk(convBusy === 1'b1, "R3 still converting", 32'(convBusy), 1);
    tick(1);
    chk(acqIdle === 1'b1 && convBusy === 1'b0, "R3 acquisition", {acqIdle, convBusy}, 2'b10);
    sampleWord = 18'h00000;
    readWord(18'h2A5C3, "R5");

    // R10: stray serial clocks, then reread from MSB
    sckPulse(); sckPulse();
    sdiIn = 1'b1; tick(4);
    sckPulse();
    chk(sdoOe === 1'b0, "R10 stray clock", 32'(sdoOe), 0);
    readWord(18'h2A5C3, "R10");
    sdiIn = 1'b1; tick(4);

    // R9: abort mid-read
    sdiIn = 1'b0; tick(4);
    sckPulse(); sckPulse();
    sdiIn = 1'b1; tick(4);
    chk(sdoOe === 1'b0, "R9 abort releases", 32'(sdoOe), 0);

    // R4: convert line drops
    cnvIn = 1'b0; tick(4);
    chk(acqIdle === 1'b0 && convBusy === 1'b0, "R4 back to idle", {acqIdle, convBusy}, 2'b00);

    // R8: stale readback during a long conversion
    startConv(16'd200, 18'h15A0F);
    tick(10);
    readWord(18'h2A5C3, "R8");
    chk(staleRead === 1'b1 && convBusy === 1'b1, "R8 flag", {staleRead, convBusy}, 2'b11);
    sdiIn = 1'b1;
    tick(200);
    chk(acqIdle === 1'b1 && protoErr === 1'b0, "R7 no error when select high",
        {acqIdle, protoErr}, 2'b10);
    readWord(18'h15A0F, "R5 new result");
    sdiIn = 1'b1; cnvIn = 1'b0; tick(4);

    // R7: select held low across the end of conversion
    startConv(16'd150, 18'h3FFFF);
    tick(8);
    readWord(18'h15A0F, "R8 second");
    tick(150);
    chk(protoErr === 1'b1 && sdoOe === 1'b0 && acqIdle === 1'b1, "R7 violation",
        {protoErr, sdoOe, acqIdle}, 3'b101);
    sdiIn = 1'b1; cnvIn = 1'b0; tick(4);

    // R3 boundary: zero cycles acts as one
    startConv(16'd0, 18'h20001);
    tick(3);
    chk(convBusy === 1'b1, "R3 one-cycle conversion", 32'(convBusy), 1);
    tick(1);
    chk(acqIdle === 1'b1, "R3 one-cycle done", 32'(acqIdle), 1);
    chk(protoErr === 1'b0 && staleRead === 1'b0, "R1 flags cleared",
        {protoErr, staleRead}, 2'b00);
    readWord(18'h20001, "R5 boundary");
    cnvIn = 1'b0; sdiIn = 1'b1; tick(6);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule